// File: doc/BRIEF.md
# Grouped Least-Recently-Granted Arbiter

This block picks one winner among a set of requesters split into equal-sized groups. The groups rank against each other by a fixed priority: the group holding the lowest-numbered requesters always wins over any higher group. Inside the winning group, the winner is the active member that has gone longest without a grant. Each group keeps its own recency order, so a burst of traffic in one group never changes the order of another.

The grant is combinational. It follows the request vector and the stored orders in the same cycle. The order of the winning group is rewritten at the next rising clock edge. The winner moves to the tail of its group's order, and the members that were behind it each move up one place. A typical use is an interconnect port that serves a few latency-critical masters in group 0 and shares what is left fairly among the masters in group 1.

Top module: `grp_lrg_arbiter`

## Requirements
- R1: At most one bit of `gnt` is high in any cycle, and exactly one is high whenever any bit of `req` is high.
- R2: `gnt_valid` is high exactly when some bit of `req` is high. With no request, `gnt` is all zeros. Both are low out of reset when `req` is zero.
- R3: A `gnt` bit is high only when the `req` bit with the same index is high.
- R4: Requester n belongs to group n / GROUP_SIZE, and its local index is n % GROUP_SIZE. While any requester of a lower-numbered group is active, no requester of a higher-numbered group is granted.
- R5: Within the winning group, the grant goes to the active member that stands first in the group's order. After reset, every group's order is ascending by local index, so the lowest active local index wins first.
- R6: On the clock edge after a member is granted, that member moves to the last place in its group's order. The members that were ahead of it keep their places, and the members that were behind it each move up one place.
- R7: The order of a group changes only on an edge where one of its own members was granted. Cycles with no request, and cycles where another group wins, leave it unchanged.
- R8: The grant reflects the request vector of the same cycle, with no register between `req` and `gnt`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; orders update on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset; restores ascending orders |
| req | input | NUM_GROUPS*GROUP_SIZE | Request vector, one bit per requester |
| gnt | output | NUM_GROUPS*GROUP_SIZE | One-hot grant vector, all zeros when idle |
| gnt_valid | output | 1 | High when a grant is issued this cycle |

## Verification
The bench holds its own recency queue for each group and checks the grant in every cycle. It drives a full request vector to confirm rotation. A design that rotated only on the index, or that forgot the tail move, would grant the same member twice in a row or skip one. It keeps group 0 busy while group 1 waits, then releases group 1. A design that updated every group on every grant would show a different group 1 winner from the expected one. Sparse and shifting subsets catch round-robin-by-pointer designs, which pick the next index rather than the least recently granted. Idle cycles and single requests on each line check the zero grant and the same-cycle response.

// File: rtl/lrg_pkg.sv
package lrg_pkg;
  localparam int MAX_GROUPS = 32;

  // isolate the lowest set bit of a vector
  function automatic logic [MAX_GROUPS-1:0] lowest_set(input logic [MAX_GROUPS-1:0] v);
    return v & (~v + MAX_GROUPS'(1));
  endfunction
endpackage

// File: rtl/lrg_group.sv
module lrg_group #(
  parameter int GROUP_SIZE = 4,
  localparam int IDXW = (GROUP_SIZE > 1) ? $clog2(GROUP_SIZE) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [GROUP_SIZE-1:0] req_i,
  input  logic                  upd_i,
  output logic [GROUP_SIZE-1:0] gnt_o,
  output logic                  any_o
);
  // position 0 holds the member granted least recently
  logic [GROUP_SIZE-1:0][IDXW-1:0] order_q, order_d;
  logic [GROUP_SIZE-1:0]           hit;
  logic [IDXW-1:0]                 win_pos, win_idx;
  logic                            take;

  function automatic logic [IDXW-1:0] first_hit(input logic [GROUP_SIZE-1:0] h);
    logic [IDXW-1:0] r;
    r = '0;
    for (int p = GROUP_SIZE - 1; p >= 0; p--)
      if (h[p]) r = IDXW'(p);
    return r;
  endfunction

  always_comb begin
    for (int p = 0; p < GROUP_SIZE; p++)
      hit[p] = req_i[order_q[p]];
  end

  assign any_o   = |hit;
  assign win_pos = first_hit(hit);
  assign win_idx = order_q[win_pos];
  assign gnt_o   = any_o ? (GROUP_SIZE'(1) << win_idx) : '0;
  assign take    = upd_i && any_o;

  always_comb begin
    for (int p = 0; p < GROUP_SIZE; p++) begin
      if (p < int'(win_pos))       order_d[p] = order_q[p];
      else if (p < GROUP_SIZE - 1) order_d[p] = order_q[p+1];
      else                         order_d[p] = win_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < GROUP_SIZE; p++) order_q[p] <= IDXW'(p);
    end else if (take) begin
      order_q <= order_d;
    end
  end

  // R6
  tail_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> order_q[GROUP_SIZE-1] == $past(win_idx));

  // R7
  order_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(order_q));

  // R3
  local_gnt_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_o & ~req_i) == '0);
endmodule

// File: rtl/group_prio.sv
module group_prio #(
  parameter int NUM_GROUPS = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_GROUPS-1:0] any_i,
  output logic [NUM_GROUPS-1:0] sel_o
);
  import lrg_pkg::*;
  logic [MAX_GROUPS-1:0] wide;

  assign wide  = lowest_set(MAX_GROUPS'(any_i));
  assign sel_o = wide[NUM_GROUPS-1:0];

  // R1
  group_sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|any_i) |-> $onehot(sel_o));
endmodule

// File: rtl/grp_lrg_arbiter.sv
module grp_lrg_arbiter #(
  parameter int NUM_GROUPS = 2,
  parameter int GROUP_SIZE = 4,
  localparam int N = NUM_GROUPS * GROUP_SIZE
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt,
  output logic         gnt_valid
);
  logic [NUM_GROUPS-1:0] grp_any, grp_sel;
  logic [N-1:0]          grp_gnt;

  group_prio #(.NUM_GROUPS(NUM_GROUPS)) u_prio (
    .clk(clk), .rst_n(rst_n), .any_i(grp_any), .sel_o(grp_sel)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    lrg_group #(.GROUP_SIZE(GROUP_SIZE)) u_grp (
      .clk   (clk),
      .rst_n (rst_n),
      .req_i (req[g*GROUP_SIZE +: GROUP_SIZE]),
      .upd_i (grp_sel[g]),
      .gnt_o (grp_gnt[g*GROUP_SIZE +: GROUP_SIZE]),
      .any_o (grp_any[g])
    );
    assign gnt[g*GROUP_SIZE +: GROUP_SIZE] =
      grp_gnt[g*GROUP_SIZE +: GROUP_SIZE] & {GROUP_SIZE{grp_sel[g]}};

    if (g > 0) begin : g_prio_chk
      // R4
      lower_group_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|req[g*GROUP_SIZE-1:0]) |-> gnt[g*GROUP_SIZE +: GROUP_SIZE] == '0);
    end
  end

  assign gnt_valid = |grp_any;

  // R1
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt) && ((|req) -> $onehot(gnt)));

  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid == (gnt != '0));

  // R3
  gnt_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);
endmodule

// File: tb/tb_grp_lrg_arbiter.sv
`timescale 1ns/1ps
module tb_grp_lrg_arbiter;
  localparam int G = 2;
  localparam int S = 4;
  localparam int N = G * S;

  logic         clk = 0;
  logic         rst_n = 0;
  logic [N-1:0] req = '0;
  logic [N-1:0] gnt;
  logic         gnt_valid;

  int errors = 0;
  int checks = 0;
  int q [G][S];

  grp_lrg_arbiter #(.NUM_GROUPS(G), .GROUP_SIZE(S)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .gnt(gnt), .gnt_valid(gnt_valid)
  );

  always #2.5 clk = ~clk;

  task automatic model_reset();
    for (int g = 0; g < G; g++)
      for (int p = 0; p < S; p++) q[g][p] = p;
  endtask

  task automatic check(input string tag, input logic [N-1:0] exp_g, input logic exp_v);
    checks++;
    if (gnt !== exp_g || gnt_valid !== exp_v) begin
      errors++;
      $display("FAIL %s req=%b gnt=%b valid=%b expected gnt=%b valid=%b",
               tag, req, gnt, gnt_valid, exp_g, exp_v);
    end
  endtask

  // one cycle: drive, check against the queue model, then age the model
  task automatic step(input string tag, input logic [N-1:0] r);
    logic [N-1:0] eg;
    int wg, wp;
    @(negedge clk);
    req = r;
    #1;
    eg = '0; wg = -1; wp = -1;
    for (int g = 0; g < G && wg < 0; g++)
      for (int p = 0; p < S && wg < 0; p++)
        if (r[g*S + q[g][p]]) begin wg = g; wp = p; end
    if (wg >= 0) eg[wg*S + q[wg][wp]] = 1'b1;
    check(tag, eg, wg >= 0);
    if (wg >= 0) begin
      int w = q[wg][wp];
      for (int p = wp; p < S - 1; p++) q[wg][p] = q[wg][p+1];
      q[wg][S-1] = w;
    end
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    check("R2 reset idle", '0, 1'b0);
    step("R2 idle", '0);
  endtask

  task automatic t_single();
    for (int i = 0; i < N; i++) step("R8 R3 single line", N'(1) << i);
    step("R2 idle after singles", '0);
  endtask

  task automatic t_rotate();
    for (int k = 0; k < 6; k++) step("R6 R1 full rotation", '1);
  endtask

  task automatic t_group1();
    for (int k = 0; k < 5; k++) step("R5 group1 alone", 8'hF0);
  endtask

  task automatic t_priority();
    step("R4 group0 bit3 vs group1", 8'hF8);
    step("R4 group0 bit0 vs group1", 8'h31);
    step("R7 group1 after hold", 8'hF0);
    step("R7 group1 next", 8'hF0);
  endtask

  task automatic t_sparse();
    step("R6 sparse a", 8'h05);
    step("R6 sparse b", 8'h05);
    step("R6 sparse c", 8'h07);
    step("R6 sparse d", 8'h06);
    step("R6 sparse e", 8'h0F);
    step("R7 idle hold", 8'h00);
    step("R6 sparse f", 8'h0F);
    step("R3 mixed", 8'hA0);
    step("R3 mixed 2", 8'hA0);
  endtask

  task automatic t_reset_order();
    rst_n = 0;
    model_reset();
    @(negedge clk);
    rst_n = 1;
    step("R5 ascending after reset", 8'h0E);
    step("R5 ascending group1", 8'hC0);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_single();
    t_rotate();
    t_group1();
    t_priority();
    t_sparse();
    t_reset_order();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule